// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked bridge between a simple single-request port inside the chip and an external asynchronous static RAM of 262,144 words by 16 bits. The RAM has one bidirectional data bus, an active-low chip select, write enable and output enable, and one active-low strobe per byte lane. The controller accepts one request at a time, holds it in registers, drives the strobe sequence for a read or a write, and returns read data with a one-cycle completion pulse.

Every phase length is a whole number of clock cycles. Each length is derived from a nanosecond parameter and the clock period, rounded up. The data bus is split into an output value, an output enable and an input value, so that the tri-state buffer sits in the pad ring. After every read the controller leaves the bus idle for a turnaround window before it drives anything. During a write the output enable stays high, so the shorter write-pulse limit applies.

Top module: `sram_port_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_bs_n` is all ones, and `mem_dq_oe`, `busy` and `rsp_done` are 0.
- R2: A read request accepted at a clock edge holds `mem_cs_n` and `mem_oe_n` low with `mem_dq_oe` low for AA_CYC = ceil(T_AA_NS/CLK_NS) cycles. `rsp_rdata` is captured from `mem_dq_in` on the last edge of that window.
- R3: Byte lane i is bits 8i+7:8i, and its strobe is `mem_bs_n[i]` (bit 0 is bits 7:0, bit 1 is bits 15:8). A request strobes lane i only when `req_ben[i]` is 1. On a read, the lanes not selected return 0 in `rsp_rdata`.
- R4: A write first spends one setup cycle with `mem_we_n` high and data driven. It then holds `mem_we_n` low for WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles. `mem_oe_n` stays high whenever `mem_we_n` is low.
- R5: A write changes only the RAM lanes selected by `req_ben`. The other lanes keep their earlier contents.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After a read the strobes are released for HZ_CYC = ceil(T_HZ_NS/CLK_NS) cycles before the block goes idle, so the bus is never driven by both sides at once.
- R7: `busy` is 1 from the accepting edge until the block is idle again. A `req_valid` seen while `busy` is 1 is ignored.
- R8: With the defaults (8 ns clock, 10/7/5/5 ns limits), a read and a write each keep `busy` high for exactly 3 cycles.
- R9: Write data and the address stay driven and unchanged for one cycle after `mem_we_n` rises. The RAM sees at least T_DW_NS of stable data before that rising edge.
- R10: `rsp_done` is a single-cycle pulse for each accepted request. It appears on the last busy cycle (the default timing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ben | input | DATA_W/8 | Byte-lane select, bit i = bits 8i+7:8i |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_bs_n | output | DATA_W/8 | RAM byte-lane strobes, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data from the data pads |

## Verification
The hardest situation to reach from the ports is the bus handover: a write issued on the very cycle after a read finishes, while the RAM may still be driving its output-disable tail. The bench issues every request at the first idle cycle, with no gap. It models the RAM at 1 ns resolution, including the access delay, the drive tail after disable, the pulse width and the data-setup rules. Any overlap of drivers, early capture or short write pulse therefore shows up as a counted fault. Random read/write mixes over a small address set with random lane masks make partial-lane merges and read-after-write hits frequent. Directed cases cover empty masks and a request injected while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrl_state_t;

  // whole clock cycles covering a nanosecond limit, never below one
  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int AA_CYC = 2,
  parameter int WP_CYC = 1,
  parameter int HZ_CYC = 1,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output ctrl_state_t      state_q,
  output ctrl_state_t      state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] AA_LD = CNT_W'(AA_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d = ST_RD_ACCESS;
            tmr_val = AA_LD;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (tmr_expired) begin
          state_d  = ST_RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = HZ_LD;
        end
      end
      ST_RD_TURN: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      ST_WR_PULSE: begin
        if (tmr_expired) state_d = ST_WR_RECOVER;
      end
      ST_WR_RECOVER: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              lane_sel,
  input  logic [LANE_W-1:0] wdata,
  input  logic              active_d,
  input  logic              capture,
  input  logic [LANE_W-1:0] dq_in,
  output logic              strobe_n,
  output logic [LANE_W-1:0] dq_out,
  output logic [LANE_W-1:0] rdata
);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      strobe_n <= 1'b1;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        sel_q  <= lane_sel;
        dq_out <= wdata;
      end
      strobe_n <= !(active_d && (accept ? lane_sel : sel_q));
      if (capture) rdata <= sel_q ? dq_in : '0;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 8,
  parameter int T_AA_NS = 10,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5,
  parameter int T_HZ_NS = 5,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_ben,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANE_W  = 8;
  localparam int AA_CYC  = cycles_for(T_AA_NS, CLK_NS);
  localparam int WP_CYC  = max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_DW_NS, CLK_NS));
  localparam int HZ_CYC  = cycles_for(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = max2(AA_CYC, max2(WP_CYC, HZ_CYC));
  localparam int CNT_W   = max2(1, $clog2(MAX_CYC + 1));

  ctrl_state_t      state_q, state_d;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, capture, active_d, drive_d, wr_end;

  sram_ctrl_fsm #(
    .AA_CYC(AA_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_expired(tmr_expired), .state_q(state_q), .state_d(state_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign capture  = (state_q == ST_RD_ACCESS) && tmr_expired;
  assign wr_end   = (state_q == ST_WR_PULSE) && (state_d == ST_WR_RECOVER);
  assign drive_d  = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                    (state_d == ST_WR_RECOVER);
  assign active_d = drive_d || (state_d == ST_RD_ACCESS);

  // registered strobes, all derived from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      busy      <= 1'b0;
      rsp_done  <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_cs_n  <= !active_d;
      mem_oe_n  <= !(state_d == ST_RD_ACCESS);
      mem_we_n  <= !(state_d == ST_WR_PULSE);
      mem_dq_oe <= drive_d;
      busy      <= (state_d != ST_IDLE);
      rsp_done  <= capture || wr_end;
      if (accept) mem_addr <= req_addr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst(rst), .accept(accept), .lane_sel(req_ben[g]),
      .wdata(req_wdata[g*LANE_W +: LANE_W]), .active_d(active_d),
      .capture(capture), .dq_in(mem_dq_in[g*LANE_W +: LANE_W]),
      .strobe_n(mem_bs_n[g]), .dq_out(mem_dq_out[g*LANE_W +: LANE_W]),
      .rdata(rsp_rdata[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 8,
  parameter int T_AA_NS = 10,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_done,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int AA_CYC = cycles_for(T_AA_NS, CLK_NS);
  localparam int WP_CYC = max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_DW_NS, CLK_NS));

  logic [7:0] oe_cnt, we_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_cnt <= '0;
      we_cnt <= '0;
    end else begin
      oe_cnt <= mem_oe_n ? 8'd0 : ((oe_cnt == 8'hFF) ? oe_cnt : oe_cnt + 8'd1);
      we_cnt <= mem_we_n ? 8'd0 : ((we_cnt == 8'hFF) ? we_cnt : we_cnt + 8'd1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rsp_done));

  assert_access_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_cnt == 8'(AA_CYC)));

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_cnt == 8'(WP_CYC)));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  assert_turn_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (!mem_dq_oe && mem_cs_n));

  assert_busy_covers_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> busy);

  assert_data_held_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
  .T_AA_NS(T_AA_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_done(rsp_done),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_addr(mem_addr)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps
module sram_port_ctrl_bench;

  localparam int AW = 18;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_ben = '0;
  logic          busy, rsp_done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [DW-1:0] bus = 16'hA5A5;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_bs_n;

  sram_port_ctrl u_sram_port_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
    .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(bus)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int contention = 0, wviol = 0;
  logic [DW-1:0] ram_arr [int];
  logic [DW-1:0] ref_arr [int];

  function automatic int ceil_ns(input int ns);
    return (ns + 7) / 8;
  endfunction
  // R8: expected busy lengths from the timing rules at an 8 ns clock
  localparam int RD_BUSY = 3;
  localparam int WR_BUSY = 3;

  function automatic logic [DW-1:0] ram_word(input logic [AW-1:0] a);
    return ram_arr.exists(int'(a)) ? ram_arr[int'(a)] : 16'h0;
  endfunction
  function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
    return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 16'h0;
  endfunction
  function automatic logic [DW-1:0] lane_mask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // RAM model at 1 ns resolution, offset half a nanosecond from clock edges
  initial begin
    real now, t_addr, t_we_fall, t_dchg;
    real t_on [2];
    real t_off [2];
    bit  en_prev [2];
    logic [AW-1:0] addr_prev;
    logic we_prev;
    logic [DW-1:0] nb;
    logic [DW-1:0] word;
    t_addr = 0.0; t_we_fall = 0.0; t_dchg = 0.0;
    t_on[0] = 0.0; t_on[1] = 0.0; t_off[0] = -100.0; t_off[1] = -100.0;
    en_prev[0] = 0; en_prev[1] = 0; addr_prev = '0; we_prev = 1'b1;
    #0.5;
    forever begin
      now = $realtime;
      if (mem_addr != addr_prev) t_addr = now;
      addr_prev = mem_addr;
      word = ram_word(mem_addr);
      for (int l = 0; l < 2; l++) begin
        bit en, drv;
        en  = !rst && !mem_cs_n && !mem_oe_n && mem_we_n && !mem_bs_n[l];
        if (en && !en_prev[l]) t_on[l] = now;
        if (!en && en_prev[l]) t_off[l] = now;
        en_prev[l] = en;
        drv = en || (now - t_off[l] < 5.0);
        if (mem_dq_oe) begin
          nb[l*8 +: 8] = mem_dq_out[l*8 +: 8];
          if (drv) contention++;
        end else if (en && (now - t_addr >= 10.0) && (now - t_on[l] >= 5.0))
          nb[l*8 +: 8] = word[l*8 +: 8];
        else if (drv)
          nb[l*8 +: 8] = ~word[l*8 +: 8];
        else
          nb[l*8 +: 8] = 8'hA5;
      end
      if (nb != bus) t_dchg = now;
      bus = nb;
      if (!rst && !we_prev && mem_we_n && !mem_cs_n) begin
        if (now - t_we_fall < 7.0) wviol++;
        if (now - t_dchg < 5.0) wviol++;
        for (int l = 0; l < 2; l++)
          if (!mem_bs_n[l]) word[l*8 +: 8] = bus[l*8 +: 8];
        ram_arr[int'(mem_addr)] = word;
      end
      if (!rst && mem_we_n === 1'b0) begin
        if (!mem_oe_n) wviol++;
        if (we_prev) t_we_fall = now;
      end
      we_prev = mem_we_n;
      #1;
    end
  end

  // one request; entered and left at a negedge with busy low
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] ben, input bit poke);
    int bcnt, dcnt, dpos;
    logic [DW-1:0] rd, expv;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_ben = ben;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    bcnt = 0; dcnt = 0; dpos = 0; rd = '0;
    for (int i = 0; i < 20; i++) begin
      if (!busy) break;
      bcnt++;
      if (poke && bcnt == 1) begin
        req_valid = 1; req_write = 1; req_addr = a ^ 18'h1; req_wdata = ~d; req_ben = 2'b11;
      end else begin
        req_valid = 0;
      end
      if (rsp_done) begin dcnt++; dpos = bcnt; rd = rsp_rdata; end
      if (wr && bcnt == 1)
        chk(mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == d && mem_bs_n == ~ben,
            "R4 setup cycle", {mem_we_n, mem_oe_n, mem_dq_oe, mem_bs_n}, {3'b111, ~ben});
      if (wr && bcnt == 2)
        chk(!mem_we_n && mem_oe_n && mem_dq_oe && !mem_cs_n && mem_bs_n == ~ben,
            "R4 write pulse", {mem_we_n, mem_oe_n, mem_dq_oe, mem_bs_n}, {3'b011, ~ben});
      if (wr && bcnt == 3)
        chk(mem_we_n && mem_dq_oe && !mem_cs_n && mem_dq_out == d && mem_addr == a,
            "R9 recovery hold", {mem_we_n, mem_dq_oe, mem_cs_n}, 3'b110);
      if (!wr && bcnt == 1)
        chk(!mem_cs_n && !mem_oe_n && !mem_dq_oe && mem_bs_n == ~ben && mem_addr == a,
            "R2 read strobes", {mem_cs_n, mem_oe_n, mem_dq_oe, mem_bs_n}, {3'b000, ~ben});
      if (!wr && bcnt == 3)
        chk(mem_cs_n && mem_oe_n && !mem_dq_oe && mem_bs_n == 2'b11,
            "R6 turnaround released", {mem_cs_n, mem_oe_n, mem_dq_oe, mem_bs_n}, 5'b11011);
      @(negedge clk);
    end
    req_valid = 0;
    chk(bcnt == (wr ? WR_BUSY : RD_BUSY), "R8 busy length", bcnt, wr ? WR_BUSY : RD_BUSY);
    chk(dcnt == 1 && dpos == bcnt, "R10 done pulse", {dcnt[15:0], dpos[15:0]},
        {16'd1, bcnt[15:0]});
    if (wr) begin
      ref_arr[int'(a)] = (ref_word(a) & ~lane_mask(ben)) | (d & lane_mask(ben));
    end else begin
      expv = ref_word(a) & lane_mask(ben);
      chk(rd == expv, ben == 2'b11 ? "R2 read data" : "R3 lane read data", rd, expv);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_bs_n == 2'b11 && !mem_dq_oe && !busy && !rsp_done,
        "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, busy, rsp_done},
        8'b1111_1000);
    rst = 0;
    @(negedge clk);
    chk(!busy && mem_cs_n, "R1 idle after reset", {busy, mem_cs_n}, 2'b01);
    chk(ceil_ns(10) + ceil_ns(5) == RD_BUSY, "R8 read count rule", RD_BUSY, ceil_ns(10) + ceil_ns(5));

    // directed cases
    do_op(1, 18'h00010, 16'h1234, 2'b11, 0);
    do_op(0, 18'h00010, 16'h0, 2'b11, 0);            // R2
    do_op(1, 18'h00010, 16'hABCD, 2'b01, 0);         // R5 lower only
    do_op(0, 18'h00010, 16'h0, 2'b11, 0);
    do_op(1, 18'h00010, 16'h9876, 2'b10, 0);         // R5 upper only
    do_op(0, 18'h00010, 16'h0, 2'b11, 0);
    do_op(0, 18'h00010, 16'h0, 2'b01, 0);            // R3 upper returns 0
    do_op(0, 18'h00010, 16'h0, 2'b00, 0);            // R3 empty mask
    do_op(1, 18'h3FFFF, 16'hFEED, 2'b11, 0);         // top address
    do_op(0, 18'h3FFFF, 16'h0, 2'b11, 1);            // R7 poke while busy
    do_op(0, 18'h3FFFE, 16'h0, 2'b11, 0);            // R7 poked address untouched
    do_op(1, 18'h00020, 16'h5555, 2'b11, 1);         // R7 poke during write
    do_op(0, 18'h00021, 16'h0, 2'b11, 0);
    do_op(0, 18'h00020, 16'h0, 2'b11, 0);

    // random mix, back to back
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 16);
      if ($urandom % 2 == 1) a = a | 18'h3FFF0;
      do_op(1'($urandom % 2), a, 16'($urandom), 2'($urandom), 1'($urandom % 8 == 0));
    end

    repeat (3) @(negedge clk);
    chk(contention == 0, "R6 bus contention", contention, 0);
    chk(wviol == 0, "R9 write timing at RAM", wviol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule